// File: doc/BRIEF.md
# Programmable AND-OR Array Logic Core

This block models a small fuse-programmable logic device. Sixteen array signals, each offered in true and inverted form, form 32 columns that feed 64 product terms. The terms are grouped eight to a macrocell across eight macrocells. A parameter picks how many macrocells are registered: 0, 4, 6 or 8, placed in the middle of the row. The remaining macrocells are combinational, and each has its own product-term tri-state enable.

The fuse map is a 2048-bit configuration store. It is loaded one bit per clock through a serial data input while a load-enable input is high. Registered macrocells share the clock and one active-low output-enable input. Pin values come out inverted. Register state, and the pin value of each bidirectional combinational cell, feed back into the array as array signals.

Bidirectional pins are split into three ports. `pin_out` carries the driven value and `pin_oe` carries the enable. `pin_in` returns what the board sees on the pin.

Top module: `pal_array_core`

## Requirements
- R1: The fuse store loads one bit per rising clock edge while `cfg_en` is high. It shifts toward higher indices, so the first of 2048 bits ends at index 2047. Fuse index t*32+c belongs to product term t and column c. Column 2k is signal k in true form and column 2k+1 is signal k in inverted form.
- R2: A fuse value of 1 connects its column to the term. A term is the AND of its connected columns. A term with no connected column is 1. A term that connects both forms of one signal is 0.
- R3: Registered macrocell i captures the OR of terms 8i..8i+7 on each rising clock edge. Its pin drives the inverse of the register.
- R4: Combinational macrocell i drives the inverse of the OR of terms 8i+1..8i+7. Term 8i is its output enable.
- R5: Every registered macrocell's `pin_oe` equals the inverse of `oe_n`, whatever the array holds. Registers keep counting while their outputs are disabled.
- R6: A synchronous `rst` sets every register to 1, so every registered pin reads 0. `rst` wins over the array.
- R7: Array signals 0..D-1 are the dedicated inputs. The following signals are cell feedback in rising cell order. A registered cell feeds back its register; a combinational cell feeds back `pin_in` of that cell.
- R8: With NREG = 0 there are 10 dedicated inputs. Cells 0 and 7 are output-only and signals 10..15 come from cells 1..6. With NREG = 4 the registered cells are 2..5; with NREG = 6 they are 1..6; with NREG = 8 they are all cells. Registered variants have 8 dedicated inputs.
- R9: While `cfg_en` is high, every `pin_oe` is 0 and the registers hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registers and the fuse loader |
| rst | input | 1 | Synchronous reset; sets all registers to 1 |
| oe_n | input | 1 | Shared active-low enable for registered pins |
| ded_in | input | 10 if NREG=0, else 8 | Dedicated array inputs |
| pin_in | input | 8 | Value seen on each pin, used as feedback by combinational cells |
| cfg_en | input | 1 | Fuse load enable |
| cfg_din | input | 1 | Serial fuse data |
| pin_out | output | 8 | Inverted macrocell values |
| pin_oe | output | 8 | Per-pin drive enable |

## Verification
A misplaced fuse or a wrong column order changes a decoded pin in the same cycle the inputs change. A wrong feedback mapping breaks the programmed counter on its next count edge. A register that does not power up high, or that advances while the fuse store is loading, shows the wrong pin pattern at the first sample after the event. The bench walks a counter-and-decoder program through enable, clear, wrap and reload, and checks every pin each cycle. It also loads a second, all-combinational instance to exercise the wider input map.

// File: rtl/pal_array_core.sv
module pal_array_core #(
  parameter int NREG = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              oe_n,
  input  logic [((NREG == 0) ? 10 : 8)-1:0] ded_in,
  input  logic [7:0]                        pin_in,
  input  logic                              cfg_en,
  input  logic                              cfg_din,
  output logic [7:0]                        pin_out,
  output logic [7:0]                        pin_oe
);
  localparam int NCELL  = 8;
  localparam int NSIG   = 16;
  localparam int NCOL   = 2 * NSIG;
  localparam int TPC    = 8;
  localparam int NTERM  = NCELL * TPC;
  localparam int NFUSE  = NTERM * NCOL;
  localparam int NDED   = (NREG == 0) ? 10 : 8;
  localparam int FB_OFS = (NREG == 0) ? 1 : 0;
  localparam int REG_LO = (NCELL - NREG) / 2;
  localparam logic [NCELL-1:0] REG_MASK = NCELL'(((1 << NREG) - 1) << REG_LO);

  logic [NFUSE-1:0] fuse;
  logic [NSIG-1:0]  sig;
  logic [NCOL-1:0]  cols;
  logic [NTERM-1:0] pt;
  logic [NCELL-1:0] d, q;
  logic             unused_bits;

  always_ff @(posedge clk)
    if (cfg_en) fuse <= {fuse[NFUSE-2:0], cfg_din};

  for (genvar k = 0; k < NSIG; k++) begin : g_sig
    if (k < NDED) begin : g_ded
      assign sig[k] = ded_in[k];
    end else begin : g_fb
      localparam int C = k - NDED + FB_OFS;
      if (REG_MASK[C]) begin : g_q
        assign sig[k] = q[C];
      end else begin : g_pin
        assign sig[k] = pin_in[C];
      end
    end
    assign cols[2*k]   = sig[k];
    assign cols[2*k+1] = ~sig[k];
  end

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    assign pt[t] = &(~fuse[t*NCOL +: NCOL] | cols);
  end

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    if (REG_MASK[i]) begin : g_reg
      assign d[i]       = |pt[i*TPC +: TPC];
      assign pin_out[i] = ~q[i];
      assign pin_oe[i]  = ~oe_n & ~cfg_en;
    end else begin : g_comb
      assign d[i]       = 1'b1;
      assign pin_out[i] = ~|pt[i*TPC+1 +: TPC-1];
      assign pin_oe[i]  = pt[i*TPC] & ~cfg_en;
    end
  end

  always_ff @(posedge clk)
    if (rst)          q <= '1;
    else if (!cfg_en) q <= d;

  assign unused_bits = ^{pin_in, q, oe_n};

  p_shift_in_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> fuse[0] == $past(cfg_din));
  p_shift_along_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> fuse[NFUSE-1:1] == $past(fuse[NFUSE-2:0]));
  p_reg_enable_r5: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |-> (pin_oe & REG_MASK) == ({NCELL{~oe_n}} & REG_MASK));
  p_reset_pins_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out & REG_MASK) == '0);
  p_fixed_bits_r8: assert property (@(posedge clk) disable iff (rst)
    (q | REG_MASK) == '1);
  p_hold_load_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> q == $past(q));
  p_quiet_load_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> pin_oe == '0);
endmodule

// File: tb/tb_pal_array_core.sv
module tb_pal_array_core;
  logic clk = 0, rst = 1, oe_n = 0, cfg_en = 0, cfg_en_b = 0, cfg_din = 0;
  logic [7:0] ded = 0, pin_in = 0, pin_in_b = 0;
  logic [9:0] ded_b = 0;
  logic [7:0] pin_out, pin_oe, pin_out_b, pin_oe_b;
  logic [2047:0] img;
  logic [3:0] cnt;
  int checks = 0, fails = 0;

  pal_array_core #(.NREG(4)) dut (.clk(clk), .rst(rst), .oe_n(oe_n), .ded_in(ded),
    .pin_in(pin_in), .cfg_en(cfg_en), .cfg_din(cfg_din), .pin_out(pin_out), .pin_oe(pin_oe));
  pal_array_core #(.NREG(0)) dut_l8 (.clk(clk), .rst(rst), .oe_n(oe_n), .ded_in(ded_b),
    .pin_in(pin_in_b), .cfg_en(cfg_en_b), .cfg_din(cfg_din), .pin_out(pin_out_b), .pin_oe(pin_oe_b));

  always #4 clk = ~clk;

  localparam int NV = 14;
  localparam logic [15:0] VEC [NV] = '{16'h0001, 16'h4005, 16'h4039, 16'h003D, 16'h4031,
    16'hBF21, 16'h0000, 16'h401C, 16'h0003, 16'h0001, 16'h0011, 16'h4025, 16'h0002, 16'h0001};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic term(input int t, input logic [15:0] tm, input logic [15:0] cm);
    for (int k = 0; k < 16; k++) begin
      img[t*32+2*k]   = tm[k];
      img[t*32+2*k+1] = cm[k];
    end
  endtask

  task automatic load(input bit to_b);
    for (int i = 2047; i >= 0; i--) begin
      @(negedge clk);
      cfg_din = img[i];
      if (to_b) cfg_en_b = 1; else cfg_en = 1;
      if (i == 1000) begin
        #1;
        chk("R9 outputs off while loading", to_b ? pin_oe_b : pin_oe, 8'h00);
      end
    end
    @(negedge clk);
    cfg_en = 0;
    cfg_en_b = 0;
  endtask

  function automatic logic [7:0] exp_out(input logic [3:0] c, input logic [7:0] di, input logic [7:0] pi);
    return {~(pi[6] & di[5]), ~(di[3:2] == 2'd2), ~c, ~(di[3:2] == 2'd1), ~(di[3:2] == 2'd0)};
  endfunction

  function automatic logic [3:0] nxt(input logic [3:0] c, input logic [7:0] di);
    return di[1] ? 4'd0 : (di[0] ? c + 4'd1 : c);
  endfunction

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL R1..: watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R6 reset pins low", pin_out & 8'h3C, 8'h00);
    chk("R5 registered enables on", pin_oe & 8'h3C, 8'h3C);

    img = '1;
    term(0, 0, 0);            term(1, 0, 16'h000C);
    term(8, 0, 0);            term(9, 16'h0004, 16'h0008);  term(10, 16'h0040, 16'h0040);
    term(16, 16'h0400, 16'h0003); term(17, 16'h0001, 16'h0402);
    term(24, 16'h0800, 16'h0003); term(25, 16'h0800, 16'h0402); term(26, 16'h0401, 16'h0802);
    term(32, 16'h1000, 16'h0003); term(33, 16'h1000, 16'h0402); term(34, 16'h1000, 16'h0802);
    term(35, 16'h0C01, 16'h1002);
    term(40, 16'h2000, 16'h0003); term(41, 16'h2000, 16'h0402); term(42, 16'h2000, 16'h0802);
    term(43, 16'h2000, 16'h1002); term(44, 16'h1C01, 16'h2002);
    term(48, 16'h0010, 0);    term(49, 16'h0008, 16'h0004);
    term(56, 16'h0010, 0);    term(57, 16'h4020, 0);
    load(0);
    rst = 0;
    cnt = 4'hF;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ded = VEC[i][7:0];
      pin_in = VEC[i][15:8];
      #1;
      chk("R1 R2 R3 R4 R7 pin values", pin_out, exp_out(cnt, ded, pin_in));
      chk("R4 R5 enables", pin_oe, {ded[4], ded[4], 4'hF, 2'b11});
      cnt = nxt(cnt, ded);
    end

    ded = 0;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; cnt = 4'hF;
    #1 chk("R6 reset restores high registers", pin_out & 8'h3C, 8'h00);
    ded = 8'h01;
    @(negedge clk); cnt = 4'h0;
    #1 chk("R3 wrap from power-up state", pin_out & 8'h3C, 8'h3C);

    oe_n = 1;
    @(negedge clk); cnt = nxt(cnt, ded);
    #1 chk("R5 shared disable", pin_oe & 8'h3C, 8'h00);
    chk("R5 counts while disabled", pin_out & 8'h3C, {2'b00, ~cnt, 2'b00});
    oe_n = 0;
    ded = 8'h03;
    @(negedge clk); cnt = 4'h0;
    #1 chk("R2 R3 clear over enable", pin_out & 8'h3C, 8'h3C);

    ded = 8'h01;
    repeat (5) begin
      @(negedge clk); cnt = nxt(cnt, ded);
    end
    #1 chk("R3 counted to five", pin_out & 8'h3C, {2'b00, ~cnt, 2'b00});
    ded = 8'h00;
    load(0);
    #1 chk("R9 registers hold across reload", pin_out & 8'h3C, {2'b00, ~cnt, 2'b00});
    ded = 8'h01;
    @(negedge clk); cnt = nxt(cnt, ded);
    #1 chk("R9 counting resumes", pin_out & 8'h3C, {2'b00, ~cnt, 2'b00});

    rst = 1;
    @(negedge clk); rst = 0;
    #1 chk("R6 reset beats count enable", pin_out & 8'h3C, 8'h00);

    img = '1;
    term(0, 0, 0);  term(1, 16'h0200, 0);
    term(56, 0, 0); term(57, 16'h0401, 0);
    load(1);
    ded_b = 10'h201; pin_in_b = 8'h02;
    #1 chk("R8 R7 ten-input variant pins", pin_out_b, {1'b0, 6'h3F, 1'b0});
    chk("R8 R4 ten-input variant enables", pin_oe_b, 8'h81);
    ded_b = 10'h001; pin_in_b = 8'h40;
    #1 chk("R8 R7 cell1 feedback only", pin_out_b, {1'b1, 6'h3F, 1'b1});

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule